// File: doc/BRIEF.md
# Flash Operation Status Output Generator

This block models, on the device side, the status a parallel NOR flash shows on its read data bus while an internal program or erase runs. A one-cycle start pulse launches a program (address and byte) or a sector erase (any address inside the sector). Each start carries a flag saying that the target is protected. While the operation runs, the active-low busy output is held low. Reads then return status rather than array data. Bit 7 shows data-polling, and its meaning differs between program and erase. Bit 6 flips on every read strobe.

A protected target does not change the array. It still produces a short, timed busy period that uses the same status encoding, and then the block falls back to read mode. The normal and abort durations are parameters counted in clock cycles. Between operations, reads return bytes from a small internal array that resets to the erased value 0xFF. A sector is the group of addresses that share the upper `SECT_W` address bits.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, and after a reset that interrupts an operation, `busy_no` is 1, the toggle state is 0 and every address reads 0xFF.
- R2: While no operation is running, a read strobe at clock edge k makes `rd_data_o` show the stored byte for `rd_addr_i` after edge k. Without a strobe, `rd_data_o` holds its value.
- R3: During a program, a read of the target address shows the inverse of bit 7 of the programmed byte on bit 7. After completion, the address reads the full programmed byte.
- R4: During an erase, a read of any address in the target sector shows 0 on bit 7. After completion, every byte in that sector reads 0xFF, so bit 7 is 1.
- R5: While busy, bit 6 of each read alternates, starting from the stored toggle state, at any address. It changes per read strobe, not per cycle. Bit 6 does not change between operations.
- R6: `busy_no` falls after the edge that accepts a start. It stays low for exactly `PROG_CYC` cycles for a program, or `ERASE_CYC` cycles for an erase.
- R7: A program with the protected flag set keeps `busy_no` low for `PROG_ABORT_CYC` cycles, polls like a program, and leaves the array unchanged.
- R8: An erase with the protected flag set keeps `busy_no` low for `ERASE_ABORT_CYC` cycles and leaves the array unchanged.
- R9: A start pulse that arrives while `busy_no` is 0 is ignored. It changes neither the duration nor the target nor the array.
- R10: If program and erase start pulses come in the same idle cycle, the program is taken and the erase is dropped.
- R11: While busy, bits 5..0 come from the array byte. Bit 7 also comes from the array byte for an address outside the polled location: not the program address, or not the erased sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_start_i | input | 1 | Program start pulse |
| erase_start_i | input | 1 | Sector erase start pulse |
| op_addr_i | input | ADDR_W | Target address of the operation |
| op_data_i | input | 8 | Byte to program |
| op_prot_i | input | 1 | Target is protected |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data or status |
| busy_no | output | 1 | Low while an operation runs |

## Verification
Programs are run with bytes whose bit 7 is 0 and with bytes whose bit 7 is 1. This separates a real inversion from a constant polling value. Reads during busy come every cycle, every other cycle, and alternating between a polled location and an unrelated one. These patterns separate per-read toggling from per-cycle toggling, and show whether the status is limited to the polled location. Protected, colliding and simultaneous starts are measured by the length of the busy window and by reading the array back afterwards.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_kind_e;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/fsg_timer.sv
module fsg_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (load_i) begin
      cnt_q  <= dur_i;
      busy_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fsg_array.sv
module fsg_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SECT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_prog_i,
  input  logic              wr_erase_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_byte_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];
  logic [SECT_W-1:0] wr_sect;

  assign wr_sect   = wr_addr_i[ADDR_W-1 -: SECT_W];
  assign rd_byte_o = mem_q[rd_addr_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    logic hit_prog, hit_erase;
    assign hit_prog  = wr_prog_i && (wr_addr_i == IDX);
    assign hit_erase = wr_erase_i && (wr_sect == IDX[ADDR_W-1 -: SECT_W]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mem_q[g] <= 8'hFF;
      else if (hit_prog)  mem_q[g] <= wr_data_i;
      else if (hit_erase) mem_q[g] <= 8'hFF;
    end
  end
endmodule

// File: rtl/fsg_read_mux.sv
module fsg_read_mux #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SECT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        arr_byte_i,
  input  logic              busy_i,
  input  logic              op_prog_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic              tgt_bit7_i,
  output logic [7:0]        rd_data_o
);
  logic       tog_q;
  logic [7:0] rd_q, status;
  logic       addr_hit, sect_hit;

  assign addr_hit = (rd_addr_i == tgt_addr_i);
  assign sect_hit = (rd_addr_i[ADDR_W-1 -: SECT_W] == tgt_addr_i[ADDR_W-1 -: SECT_W]);

  always_comb begin
    status    = arr_byte_i;
    status[6] = tog_q;
    if (op_prog_i) begin
      if (addr_hit) status[7] = ~tgt_bit7_i;
    end else if (sect_hit) begin
      status[7] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 8'hFF;
      tog_q <= 1'b0;
    end else if (rd_i) begin
      if (busy_i) begin
        rd_q  <= status;
        tog_q <= ~tog_q;
      end else begin
        rd_q  <= arr_byte_i;
      end
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned ADDR_W          = 4,
  parameter int unsigned SECT_W          = 2,
  parameter int unsigned PROG_CYC        = 12,
  parameter int unsigned ERASE_CYC       = 30,
  parameter int unsigned PROG_ABORT_CYC  = 5,
  parameter int unsigned ERASE_ABORT_CYC = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [7:0]        op_data_i,
  input  logic              op_prot_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_no
);
  localparam int unsigned MAX_CYC = max4(PROG_CYC, ERASE_CYC, PROG_ABORT_CYC, ERASE_ABORT_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  op_kind_e          op_kind_q;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [7:0]        tgt_data_q;
  logic              abort_q;
  logic              busy, done, accept, op_is_prog;
  logic [CNT_W-1:0]  dur;
  logic [7:0]        arr_byte;

  assign accept     = !busy && (prog_start_i || erase_start_i);
  assign op_is_prog = (op_kind_q == OP_PROG);

  always_comb begin
    if (prog_start_i) dur = op_prot_i ? CNT_W'(PROG_ABORT_CYC)  : CNT_W'(PROG_CYC);
    else              dur = op_prot_i ? CNT_W'(ERASE_ABORT_CYC) : CNT_W'(ERASE_CYC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_kind_q  <= OP_PROG;
      tgt_addr_q <= '0;
      tgt_data_q <= 8'hFF;
      abort_q    <= 1'b0;
    end else if (accept) begin
      op_kind_q  <= prog_start_i ? OP_PROG : OP_ERASE;
      tgt_addr_q <= op_addr_i;
      tgt_data_q <= op_data_i;
      abort_q    <= op_prot_i;
    end
  end

  fsg_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .dur_i  (dur),
    .busy_o (busy),
    .done_o (done)
  );

  fsg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_prog_i  (done && !abort_q && op_is_prog),
    .wr_erase_i (done && !abort_q && !op_is_prog),
    .wr_addr_i  (tgt_addr_q),
    .wr_data_i  (tgt_data_q),
    .rd_addr_i  (rd_addr_i),
    .rd_byte_o  (arr_byte)
  );

  fsg_read_mux #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_rmux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .rd_addr_i  (rd_addr_i),
    .arr_byte_i (arr_byte),
    .busy_i     (busy),
    .op_prog_i  (op_is_prog),
    .tgt_addr_i (tgt_addr_q),
    .tgt_bit7_i (tgt_data_q[7]),
    .rd_data_o  (rd_data_o)
  );

  assign busy_no = !busy;
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SECT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_start_i,
  input logic              erase_start_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic              busy_no,
  input logic              op_is_prog,
  input logic [ADDR_W-1:0] tgt_addr_q,
  input logic [7:0]        tgt_data_q
);
  a_r6_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no && (prog_start_i || erase_start_i) |=> !busy_no);

  a_r2_hold_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));

  a_r5_toggle_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_no && $past(rd_i && !busy_no) |=> rd_data_o[6] != $past(rd_data_o[6]));

  a_r3_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no && op_is_prog && rd_i && (rd_addr_i == tgt_addr_q)
    |=> rd_data_o[7] == ~$past(tgt_data_q[7]));

  a_r4_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no && !op_is_prog && rd_i
    && (rd_addr_i[ADDR_W-1 -: SECT_W] == tgt_addr_q[ADDR_W-1 -: SECT_W])
    |=> rd_data_o[7] == 1'b0);

  a_r9_target_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no && $past(!busy_no) |-> $stable(tgt_addr_q) && $stable(tgt_data_q));
endmodule

bind flash_status_gen flash_status_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .prog_start_i  (prog_start_i),
  .erase_start_i (erase_start_i),
  .rd_i          (rd_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .busy_no       (busy_no),
  .op_is_prog    (op_is_prog),
  .tgt_addr_q    (tgt_addr_q),
  .tgt_data_q    (tgt_data_q)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int ADDR_W = 4, SECT_W = 2;
  localparam int PROG_CYC = 12, ERASE_CYC = 30, PROG_ABORT_CYC = 5, ERASE_ABORT_CYC = 18;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_start = 0, erase_start = 0, op_prot = 0, rd = 0;
  logic [ADDR_W-1:0] op_addr = '0, rd_addr = '0;
  logic [7:0] op_data = '0, rd_data;
  logic busy_n;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  flash_status_gen #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .PROG_ABORT_CYC(PROG_ABORT_CYC), .ERASE_ABORT_CYC(ERASE_ABORT_CYC)
  ) i_flash_status_gen (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(prog_start), .erase_start_i(erase_start),
    .op_addr_i(op_addr), .op_data_i(op_data), .op_prot_i(op_prot), .rd_i(rd),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_no(busy_n)
  );

  // behavioural reference
  int  m_mem [DEPTH];
  int  m_rd, m_cnt, m_taddr, m_tdata;
  bit  m_busy, m_tog, m_prog, m_abort;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_rd = 8'hFF; m_busy = 0; m_tog = 0; m_cnt = 0;
    end else begin
      if (rd) begin
        int v;
        v = m_mem[rd_addr];
        if (m_busy) begin
          v[6] = m_tog;
          if (m_prog && rd_addr == m_taddr) v[7] = ~m_tdata[7];
          if (!m_prog && (rd_addr / 4) == (m_taddr / 4)) v[7] = 1'b0;
          m_tog = ~m_tog;
        end
        m_rd = v;
      end
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (!m_abort) begin
            if (m_prog) m_mem[m_taddr] = m_tdata;
            else for (int i = 0; i < DEPTH; i++)
              if (i / 4 == m_taddr / 4) m_mem[i] = 8'hFF;
          end
        end
      end else if (prog_start || erase_start) begin
        m_busy = 1; m_prog = prog_start; m_abort = op_prot;
        m_taddr = op_addr; m_tdata = op_data;
        m_cnt = prog_start ? (op_prot ? PROG_ABORT_CYC : PROG_CYC)
                           : (op_prot ? ERASE_ABORT_CYC : ERASE_CYC);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) if (rst_n) begin
    check(rd_data == 8'(m_rd), cur_req, rd_data, m_rd);
    check(busy_n == !m_busy, {cur_req, " busy"}, busy_n, !m_busy);
  end

  task automatic read_back(int a, int exp, string req);
    cur_req = req;
    rd = 1; rd_addr = ADDR_W'(a);
    @(negedge clk);
    rd = 0;
    check(rd_data == 8'(exp), req, rd_data, exp);
  endtask

  // mode: 0 none, 1 every cycle at a, 2 alternate a/b, 3 every other cycle at a
  task automatic run_op(bit p, bit e, int a, int d, bit prot, int mode, int ra, int rb,
                        int exp_dur, string req, bit inject);
    int n = 0;
    bit prev6 = 0, have = 0;
    cur_req = req;
    prog_start = p; erase_start = e; op_addr = ADDR_W'(a); op_data = 8'(d); op_prot = prot;
    @(negedge clk);
    prog_start = 0; erase_start = 0;
    while (!busy_n && n < 200) begin
      if (inject && n == 2) begin
        prog_start = 1; erase_start = 1; op_addr = ADDR_W'(ra + 1); op_data = 8'h22; op_prot = 0;
      end else begin
        prog_start = 0; erase_start = 0;
      end
      case (mode)
        1: begin rd = 1; rd_addr = ADDR_W'(ra); end
        2: begin rd = 1; rd_addr = ADDR_W'((n % 2) ? rb : ra); end
        3: begin rd = (n % 2 == 0); rd_addr = ADDR_W'(ra); end
        default: rd = 0;
      endcase
      n++;
      @(negedge clk);
      if (rd && !busy_n) begin
        if (have) check(rd_data[6] != prev6, "R5", rd_data[6], !prev6);
        prev6 = rd_data[6]; have = 1;
      end
    end
    rd = 0; prog_start = 0; erase_start = 0;
    check(n == exp_dur, {req, " duration"}, n, exp_dur);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy_n == 1'b1, "R1", busy_n, 1);
    for (int i = 0; i < DEPTH; i++) read_back(i, 8'hFF, "R1");

    // R3/R6: bit7 of data 0, polled every cycle
    run_op(1, 0, 5, 8'h3C, 0, 1, 5, 0, PROG_CYC, "R3", 0);
    read_back(5, 8'h3C, "R3");
    // R2 hold without strobe
    cur_req = "R2"; rd_addr = 4'd0;
    repeat (3) @(negedge clk);
    check(rd_data == 8'h3C, "R2", rd_data, 8'h3C);

    // R11: bit7 of data 1, alternate polled and other address
    run_op(1, 0, 9, 8'hA5, 0, 2, 9, 2, PROG_CYC, "R11", 0);
    read_back(9, 8'hA5, "R3");

    // R4/R6 erase of sector 1 with a byte in it, reads inside and outside
    run_op(1, 0, 6, 8'h81, 0, 0, 0, 0, PROG_CYC, "R6", 0);
    run_op(0, 1, 5, 0, 0, 2, 6, 12, ERASE_CYC, "R4", 0);
    read_back(6, 8'hFF, "R4");
    read_back(5, 8'hFF, "R4");

    // R5 toggle per read, not per cycle
    run_op(1, 0, 1, 8'h7E, 0, 3, 1, 0, PROG_CYC, "R5", 0);

    // R7 protected program
    run_op(1, 0, 3, 8'h00, 1, 1, 3, 0, PROG_ABORT_CYC, "R7", 0);
    read_back(3, 8'hFF, "R7");

    // R8 protected erase of sector 2 (holds 0xA5 at 9)
    run_op(0, 1, 8, 0, 1, 1, 9, 0, ERASE_ABORT_CYC, "R8", 0);
    read_back(9, 8'hA5, "R8");

    // R9 start while busy
    run_op(1, 0, 0, 8'h11, 0, 0, 0, 0, PROG_CYC, "R9", 1);
    read_back(0, 8'h11, "R9");
    read_back(1, 8'h7E, "R9");

    // R10 simultaneous starts
    run_op(1, 1, 13, 8'h44, 0, 0, 0, 0, PROG_CYC, "R10", 0);
    read_back(13, 8'h44, "R10");
    read_back(12, 8'hFF, "R10");

    // R1 reset mid-operation
    cur_req = "R1";
    prog_start = 1; op_addr = 4'd14; op_data = 8'h00; op_prot = 0;
    @(negedge clk);
    prog_start = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check(busy_n == 1'b1, "R1", busy_n, 1);
    read_back(14, 8'hFF, "R1");
    read_back(13, 8'hFF, "R1");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule